// File: doc/BRIEF.md
# Bidirectional Pad Boundary Scan Segment

This block is a three-bit slice of a boundary scan register that wraps one bidirectional pad. It sits between the core and the pad. The core supplies output data and an output enable, and it receives the input data. The pad side supplies the sampled pad level and takes the driven data and enable. There are three scan cells, one for each of these signals. Every cell has a capture flop, which takes part in the serial chain, and an update flop, which holds the value applied in test mode.

The TAP controller and the instruction decoder live outside this block. They drive the shift, capture and update strobes and the mode select as plain inputs. In functional mode the cells are transparent. In test mode the pad is driven from the update flops of the data cell and the enable cell, and the core sees the update flop of the input cell. The serial path runs from `scan_in` through the enable cell, then the data cell, then the input cell, and leaves at `scan_out`. Because the chain order is fixed, a host that wants to load enable, data and input values shifts the input value first, then the data value, then the enable value.

All flops use the rising edge of `clk` and a synchronous active-high reset.

Top module: `bscan_pad_seg`

## Requirements
- R1: While `rst` is high at a rising clock edge, every capture flop and every update flop clears to 0. After reset, `scan_out` reads 0, and in test mode `pad_o`, `pad_oe` and `core_di` all read 0.
- R2: When `test_mode` is 0, `pad_o` follows `core_do`, `pad_oe` follows `core_oe` and `core_di` follows `pad_i`, all without a clock.
- R3: When `shift_dr` is 1, the capture flops form a shift register in the order `scan_in`, enable cell, data cell, input cell, `scan_out`. A bit on `scan_in` appears on `scan_out` after three rising edges, and `scan_out` is the input cell's capture flop.
- R4: When `capture_dr` is 1 and `shift_dr` is 0, a rising edge loads the enable cell from `core_oe`, the data cell from `core_do` and the input cell from `pad_i`.
- R5: When `shift_dr` and `capture_dr` are both 1, the cells shift and the functional inputs are ignored.
- R6: When `update_dr` is 1, a rising edge copies each capture flop into its update flop. In test mode (`test_mode` = 1), `pad_o` then shows the data cell's update flop, `pad_oe` shows the enable cell's update flop and `core_di` shows the input cell's update flop.
- R7: While `update_dr` is 0, the update flops hold their values, so in test mode the test-mode outputs do not change during shifting or capture.
- R8: When `shift_dr` and `capture_dr` are both 0, the capture flops hold their values, whatever the functional inputs do.
- R9: Changing `test_mode` selects only where the outputs come from. It does not change any capture or update flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all flops use its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears every stage |
| shift_dr | input | 1 | Shift strobe; selects the serial path into the capture flops |
| capture_dr | input | 1 | Capture strobe; loads the functional inputs when not shifting |
| update_dr | input | 1 | Update strobe; copies the capture flops into the update flops |
| test_mode | input | 1 | 0 = functional pass-through, 1 = outputs from the update flops |
| scan_in | input | 1 | Serial data into the enable cell |
| scan_out | output | 1 | Serial data out of the input cell |
| core_do | input | 1 | Output data from the core |
| core_oe | input | 1 | Output enable from the core |
| core_di | output | 1 | Input data to the core |
| pad_i | input | 1 | Level sampled at the pad |
| pad_o | output | 1 | Data driven to the pad |
| pad_oe | output | 1 | Enable for the pad driver |

## Verification
The assertions check four behaviours on every clock. Each shift moves a bit exactly one position along the chain, in the order given in R3. A capture loads the right functional input into each cell. An update copies the capture flops into the update flops. Without an update, the test-mode outputs hold still.

Some behaviours only the bench scenarios can show, because they depend on a sequence of operations seen from the ports. These are the full shift-in, update and drive sequence, the readout of captured pad and core values through `scan_out`, the priority of shifting over capture, and the fact that toggling the mode leaves the stored state alone.

// File: rtl/bscan_seg_pkg.sv
package bscan_seg_pkg;

    // Number of cells in the segment and each cell's position in the chain
    localparam int SEG_LEN  = 3;
    localparam int IDX_CTRL = 0;
    localparam int IDX_DATA = 1;
    localparam int IDX_IN   = 2;

    typedef enum logic {
        MODE_FUNC = 1'b0,
        MODE_TEST = 1'b1
    } seg_mode_e;

    typedef struct packed {
        logic shift;
        logic capture;
        logic update;
    } seg_strobe_t;

    typedef struct packed {
        logic cap;
        logic upd;
    } cell_state_t;

    // Next capture value: shifting outranks capture, otherwise hold
    function automatic logic next_cap(seg_strobe_t s, logic ser, logic func, logic cur);
        if (s.shift)
            return ser;
        else if (s.capture)
            return func;
        else
            return cur;
    endfunction

    function automatic logic next_upd(seg_strobe_t s, logic cap, logic cur);
        return s.update ? cap : cur;
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_seg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  seg_strobe_t strobe,
    input  seg_mode_e   mode,
    input  logic        func_in,
    input  logic        ser_in,
    output logic        ser_out,
    output logic        func_out,
    output logic        upd_out
);

    cell_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.cap <= next_cap(strobe, ser_in, func_in, st.cap);
            st.upd <= next_upd(strobe, st.cap, st.upd);
        end
    end

    assign ser_out  = st.cap;
    assign upd_out  = st.upd;
    assign func_out = (mode == MODE_TEST) ? st.upd : func_in;

endmodule

// File: rtl/bscan_pad_seg.sv
module bscan_pad_seg
    import bscan_seg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shift_dr,
    input  logic capture_dr,
    input  logic update_dr,
    input  logic test_mode,
    input  logic scan_in,
    output logic scan_out,
    input  logic core_do,
    input  logic core_oe,
    output logic core_di,
    input  logic pad_i,
    output logic pad_o,
    output logic pad_oe
);

    seg_strobe_t             strobe;
    seg_mode_e               mode;
    logic [SEG_LEN:0]        chain;
    logic [SEG_LEN-1:0]      func_in_v;
    logic [SEG_LEN-1:0]      func_out_v;
    logic [SEG_LEN-1:0]      cap_q;
    logic [SEG_LEN-1:0]      upd_q;

    assign strobe = '{shift: shift_dr, capture: capture_dr, update: update_dr};
    assign mode   = seg_mode_e'(test_mode);

    // Functional input of each cell, by chain position
    assign func_in_v[IDX_CTRL] = core_oe;
    assign func_in_v[IDX_DATA] = core_do;
    assign func_in_v[IDX_IN]   = pad_i;

    assign chain[0] = scan_in;

    for (genvar i = 0; i < SEG_LEN; i++) begin : g_cell
        bscan_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .strobe   (strobe),
            .mode     (mode),
            .func_in  (func_in_v[i]),
            .ser_in   (chain[i]),
            .ser_out  (chain[i+1]),
            .func_out (func_out_v[i]),
            .upd_out  (upd_q[i])
        );
        assign cap_q[i] = chain[i+1];
    end

    assign scan_out = chain[SEG_LEN];
    assign pad_oe   = func_out_v[IDX_CTRL];
    assign pad_o    = func_out_v[IDX_DATA];
    assign core_di  = func_out_v[IDX_IN];

endmodule

// File: rtl/bscan_pad_seg_chk.sv
module bscan_pad_seg_chk
    import bscan_seg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               shift_dr,
    input logic               capture_dr,
    input logic               update_dr,
    input logic               test_mode,
    input logic               scan_in,
    input logic               scan_out,
    input logic               core_do,
    input logic               core_oe,
    input logic               pad_i,
    input logic               pad_o,
    input logic               pad_oe,
    input logic               core_di,
    input logic [SEG_LEN-1:0] cap_q,
    input logic [SEG_LEN-1:0] upd_q
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            reset_clear_chk: assert (cap_q == '0 && upd_q == '0)
                else $error("stages not cleared after reset");
        end
    end

    // R3
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        shift_dr |=> cap_q[IDX_CTRL] == $past(scan_in));

    // R3
    shift_exit_chk: assert property (@(posedge clk) disable iff (rst)
        shift_dr |=> scan_out == $past(cap_q[IDX_DATA]));

    // R4
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        (capture_dr && !shift_dr) |=>
            (cap_q[IDX_IN] == $past(pad_i) && cap_q[IDX_DATA] == $past(core_do)
             && cap_q[IDX_CTRL] == $past(core_oe)));

    // R6
    update_copy_chk: assert property (@(posedge clk) disable iff (rst)
        update_dr |=> upd_q == $past(cap_q));

    // R7
    test_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (test_mode && $past(test_mode) && !$past(update_dr) && !$past(rst))
            |-> ($stable(pad_o) && $stable(pad_oe) && $stable(core_di)));

    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_dr && !capture_dr) |=> $stable(cap_q));

endmodule

bind bscan_pad_seg bscan_pad_seg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_dr   (shift_dr),
    .capture_dr (capture_dr),
    .update_dr  (update_dr),
    .test_mode  (test_mode),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .core_do    (core_do),
    .core_oe    (core_oe),
    .pad_i      (pad_i),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe),
    .core_di    (core_di),
    .cap_q      (cap_q),
    .upd_q      (upd_q)
);

// File: tb/bscan_pad_seg_test.sv
module bscan_pad_seg_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_dr = 1'b0, capture_dr = 1'b0, update_dr = 1'b0, test_mode = 1'b0;
    logic scan_in = 1'b0, core_do = 1'b0, core_oe = 1'b0, pad_i = 1'b0;
    logic scan_out, core_di, pad_o, pad_oe;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    bscan_pad_seg uut (
        .clk(clk), .rst(rst), .shift_dr(shift_dr), .capture_dr(capture_dr),
        .update_dr(update_dr), .test_mode(test_mode), .scan_in(scan_in),
        .scan_out(scan_out), .core_do(core_do), .core_oe(core_oe),
        .core_di(core_di), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Load enable c, data o, input n: the input value goes in first
    task automatic load_seg(logic c, logic o, logic n);
        shift_dr = 1'b1;
        scan_in = n; step();
        scan_in = o; step();
        scan_in = c; step();
        shift_dr = 1'b0; scan_in = 1'b0;
    endtask

    // Shift the segment out and compare: input cell first, then data, then enable
    task automatic unload_check(string req, logic c, logic o, logic n);
        shift_dr = 1'b1; scan_in = 1'b0; #1;
        check(req, "input cell", scan_out, n); step();
        check(req, "data cell",  scan_out, o); step();
        check(req, "enable cell", scan_out, c); step();
        shift_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1; step(); update_dr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step(); rst = 1'b0; #1;
        check("R1", "scan_out", scan_out, 1'b0);
        test_mode = 1'b1; #1;
        check("R1", "pad_o",   pad_o,   1'b0);
        check("R1", "pad_oe",  pad_oe,  1'b0);
        check("R1", "core_di", core_di, 1'b0);
        test_mode = 1'b0; #1;
    endtask

    task automatic t_functional();
        for (int k = 0; k < 8; k++) begin
            core_do = k[0]; core_oe = k[1]; pad_i = k[2]; #1;
            check("R2", "pad_o",   pad_o,   k[0]);
            check("R2", "pad_oe",  pad_oe,  k[1]);
            check("R2", "core_di", core_di, k[2]);
        end
    endtask

    task automatic t_shift();
        logic [9:0] pat = 10'b1101001110;
        shift_dr = 1'b1;
        for (int k = 0; k < 10; k++) begin
            scan_in = pat[k];
            step();
            if (k >= 2) check("R3", "delayed bit", scan_out, pat[k-2]);
        end
        shift_dr = 1'b0; scan_in = 1'b0;
    endtask

    task automatic t_capture();
        core_oe = 1'b1; core_do = 1'b0; pad_i = 1'b1;
        capture_dr = 1'b1; step(); capture_dr = 1'b0;
        unload_check("R4", 1'b1, 1'b0, 1'b1);
        core_oe = 1'b0; core_do = 1'b1; pad_i = 1'b0;
        capture_dr = 1'b1; step(); capture_dr = 1'b0;
        unload_check("R4", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_priority();
        core_oe = 1'b1; core_do = 1'b1; pad_i = 1'b1;
        capture_dr = 1'b1;
        load_seg(1'b0, 1'b1, 1'b0);
        capture_dr = 1'b0;
        unload_check("R5", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_update_drive();
        load_seg(1'b1, 1'b0, 1'b1);
        do_update();
        test_mode = 1'b1;
        core_do = 1'b1; core_oe = 1'b0; pad_i = 1'b0; #1;
        check("R6", "pad_o",   pad_o,   1'b0);
        check("R6", "pad_oe",  pad_oe,  1'b1);
        check("R6", "core_di", core_di, 1'b1);
    endtask

    task automatic t_hold_update();
        // Still in test mode with 1/0/1 applied; shift and capture without update
        load_seg(1'b0, 1'b1, 1'b0);
        check("R7", "pad_o after shift",  pad_o,  1'b0);
        check("R7", "pad_oe after shift", pad_oe, 1'b1);
        pad_i = 1'b1; capture_dr = 1'b1; step(); capture_dr = 1'b0;
        check("R7", "core_di after capture", core_di, 1'b1);
        load_seg(1'b0, 1'b1, 1'b0);
        do_update(); #1;
        check("R6", "pad_o new",   pad_o,   1'b1);
        check("R6", "pad_oe new",  pad_oe,  1'b0);
        check("R6", "core_di new", core_di, 1'b0);
    endtask

    task automatic t_mode_toggle();
        test_mode = 1'b0; step(); test_mode = 1'b1; step(); #1;
        check("R9", "pad_o kept",   pad_o,   1'b1);
        check("R9", "pad_oe kept",  pad_oe,  1'b0);
        check("R9", "core_di kept", core_di, 1'b0);
        unload_check("R9", 1'b0, 1'b1, 1'b0);
        test_mode = 1'b0;
    endtask

    task automatic t_idle_hold();
        load_seg(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) begin
            core_do = k[0]; core_oe = k[1]; pad_i = ~k[0];
            step();
        end
        unload_check("R8", 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_functional();
        t_shift();
        t_capture();
        t_priority();
        t_update_drive();
        t_hold_update();
        t_mode_toggle();
        t_idle_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule